// File: doc/BRIEF.md
# Framed Serial Sample Transmitter

This block sends 16-bit signed samples from an upstream producer over a three-wire synchronous serial port: a bit clock, a frame marker and a data line. All timing comes from one master clock. The bit clock runs at a quarter of the master rate, and one frame is 32 bit-clock slots long. The sample goes out two's complement, most significant bit first, in the first 16 slots. The other 16 slots carry zeros.

The sample to send is loaded into a shift register at the start of every frame. An upstream sample that arrives mid-frame waits in a holding register and goes out in the next frame. If no new sample arrives, the held value is sent again. A format pin sets two things: the bit-clock polarity, which decides whether data is stable at the rising or the falling edge, and the frame marker shape, which is either a one-slot pulse or a half-frame square wave. A rising edge on the frame sync input aborts the current frame and starts a new one.

The output enable and a time-slot pin let two transmitters share one data wire. The enable is active at whatever level the time-slot pin carries. The pad buffer is not part of the block: it appears as a data value plus a drive-enable. In a shared setup the first device has its time-slot pin low, and its frame marker drives both enables and the second device's sync input.

Top module: `serial_frame_tx`

## Requirements
- R1: The bit clock period is 4 master clock cycles and every slot starts on a slot boundary. With `fmt_sel`=1 the bit clock is low for the first two cycles of a slot and high for the last two, so data is stable across the rising edge. With `fmt_sel`=0 the levels are inverted, so data is stable across the falling edge.
- R2: With no rising edge on `fsync_in`, a frame lasts exactly 128 master clock cycles (32 slots), and frames repeat without gaps.
- R3: Slot k (0..15) carries bit 15-k of the frame's sample, and it holds that value for the whole slot.
- R4: Slots 16 to 31 of every frame carry 0 on `sdata_out`.
- R5: With `fmt_sel`=0, `fsync_out` is 1 only during slot 31. It falls as slot 0 begins.
- R6: With `fmt_sel`=1, `fsync_out` is 0 during slots 0 to 15 and 1 during slots 16 to 31.
- R7: A 0-to-1 change of `fsync_in` between two clock samples restarts the frame. Slot 0 begins in the cycle after the second clock edge following the change, which is well inside 8 master cycles, and `fsync_out` is low there.
- R8: When `fsync_in` is held at a constant level, including a constant high, no restart occurs and the frame keeps its 128-cycle period.
- R9: `sdata_drive` is 1 exactly when `oe_in` equals `slot_sel`, for all four combinations.
- R10: A sample taken with `smp_valid` is sent starting at the next frame start. A later sample accepted before that frame start replaces it. If no new sample arrives, the last one is sent again.
- R11: During and just after reset the block is at slot 0, phase 0 with a zero sample. `fsync_out` and `sdata_out` are 0, and zeros are sent until a sample is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_data | input | 16 | Signed sample from the producer |
| smp_valid | input | 1 | Sample strobe, one cycle per sample |
| fsync_in | input | 1 | External frame restart, acts on its rising edge |
| fmt_sel | input | 1 | 1: rising-edge data and square marker; 0: falling-edge data and pulse marker |
| slot_sel | input | 1 | Active level of `oe_in` |
| oe_in | input | 1 | Data line enable |
| bclk_out | output | 1 | Serial bit clock, master clock divided by 4 |
| fsync_out | output | 1 | Frame marker |
| sdata_out | output | 1 | Serial data value |
| sdata_drive | output | 1 | High when the data line is driven, low for high impedance |

## Verification
If the phase or slot counter is wrong, the bit clock shows a high or low run that is not two cycles long, or the frame marker edges land in the wrong slot. Either shows up within one 128-cycle frame. A bad shift register or holding register shows up as a wrong bit in the first frame that carries a known sample, or as a one in a padding slot. A restart detector that fires late, or on a steady high level, moves the marker from the position it should have after the second edge following the input change. The bench compares all four outputs every cycle against an independent frame model, under random format changes, restarts and sample traffic.

// File: rtl/sft_pkg.sv
package sft_pkg;
   typedef enum logic {
      FMT_FALL_PULSE  = 1'b0,
      FMT_RISE_SQUARE = 1'b1
   } fmt_e;
endpackage

// File: rtl/sft_sync_edge.sv
module sft_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   logic [STAGES-1:0] hist_q;

   generate
      if (STAGES < 2 || STAGES > 7) begin : g_bad_stages
         $error("sft_sync_edge: STAGES must lie in 2..7");
      end
   endgenerate

   // Reset to all ones: a level that is high out of reset is not an edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist_q <= '1;
      else        hist_q <= {hist_q[STAGES-2:0], din};
   end

   assign rise = hist_q[STAGES-2] & ~hist_q[STAGES-1];

   assert_rise_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/sft_timebase.sv
module sft_timebase #(
   parameter int DIV   = 4,
   parameter int SLOTS = 32,
   localparam int PH_W = $clog2(DIV),
   localparam int SL_W = $clog2(SLOTS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            restart,
   output logic [PH_W-1:0] ph,
   output logic [SL_W-1:0] slot,
   output logic            slot_end,
   output logic            frame_start
);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);
   localparam logic [SL_W-1:0] SL_LAST = SL_W'(SLOTS - 1);

   generate
      if (DIV < 2 || (DIV % 2) != 0) begin : g_bad_div
         $error("sft_timebase: DIV must be even and at least 2");
      end
      if ((1 << SL_W) != SLOTS) begin : g_bad_slots
         $error("sft_timebase: SLOTS must be a power of two");
      end
   endgenerate

   logic wrap;
   assign slot_end    = (ph == PH_LAST);
   assign wrap        = slot_end && (slot == SL_LAST);
   assign frame_start = restart | wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph   <= '0;
         slot <= '0;
      end else if (frame_start) begin
         ph   <= '0;
         slot <= '0;
      end else if (slot_end) begin
         ph   <= '0;
         slot <= slot + 1'b1;
      end else begin
         ph   <= ph + 1'b1;
      end
   end

   assert_frame_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_LAST && slot == SL_LAST) |=> (ph == '0 && slot == '0));
   assert_restart_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (ph == '0 && slot == '0));
   assert_phase_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && ph != PH_LAST) |=> (ph == $past(ph) + 1'b1 && slot == $past(slot)));
endmodule

// File: rtl/sft_payload.sv
module sft_payload #(
   parameter int SAMPLE_W = 16,
   parameter int SLOTS    = 32,
   localparam int SL_W    = $clog2(SLOTS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SAMPLE_W-1:0] smp_data,
   input  logic                smp_valid,
   input  logic                load,
   input  logic                shift,
   input  logic [SL_W-1:0]     slot,
   output logic                msb
);
   localparam logic [SL_W-1:0] SL_PAD = SL_W'(SAMPLE_W);

   generate
      if (SAMPLE_W < 2 || SAMPLE_W >= SLOTS) begin : g_bad_width
         $error("sft_payload: SAMPLE_W must be at least 2 and below SLOTS");
      end
   endgenerate

   logic [SAMPLE_W-1:0] hold_q;
   logic [SAMPLE_W-1:0] shreg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         hold_q <= '0;
      else if (smp_valid) hold_q <= smp_data;
   end

   // Zeros enter from the bottom, so padding slots come out as zero
   // without a separate gate.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     shreg_q <= '0;
      else if (load)  shreg_q <= hold_q;
      else if (shift) shreg_q <= {shreg_q[SAMPLE_W-2:0], 1'b0};
   end

   assign msb = shreg_q[SAMPLE_W-1];

   assert_pad_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (slot >= SL_PAD) |-> !msb);
endmodule

// File: rtl/sft_linectl.sv
module sft_linectl
   import sft_pkg::*;
#(
   parameter int DIV      = 4,
   parameter int SLOTS    = 32,
   parameter int SAMPLE_W = 16,
   localparam int PH_W    = $clog2(DIV),
   localparam int SL_W    = $clog2(SLOTS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PH_W-1:0] ph,
   input  logic [SL_W-1:0] slot,
   input  logic            msb,
   input  logic            fmt_sel,
   input  logic            slot_sel,
   input  logic            oe_in,
   output logic            bclk_out,
   output logic            fsync_out,
   output logic            sdata_out,
   output logic            sdata_drive
);
   localparam logic [PH_W-1:0] PH_HALF = PH_W'(DIV / 2);
   localparam logic [SL_W-1:0] SL_LAST = SL_W'(SLOTS - 1);
   localparam logic [SL_W-1:0] SL_PAD  = SL_W'(SAMPLE_W);

   fmt_e fmt;
   logic late_half;

   assign fmt       = fmt_e'(fmt_sel);
   assign late_half = (ph >= PH_HALF);

   always_comb begin
      case (fmt)
         FMT_RISE_SQUARE: begin
            bclk_out  = late_half;
            fsync_out = (slot >= SL_PAD);
         end
         default: begin
            bclk_out  = ~late_half;
            fsync_out = (slot == SL_LAST);
         end
      endcase
   end

   assign sdata_out   = msb;
   assign sdata_drive = ~(oe_in ^ slot_sel);

   assert_bclk_steady_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (ph != '0 && ph != PH_HALF && $stable(fmt_sel)) |-> $stable(bclk_out));
   assert_pulse_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!fmt_sel && $stable(fmt_sel) && ph == '0 && slot == '0 && $past(slot) == SL_LAST)
      |-> $fell(fsync_out));
   assert_square_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt_sel && $stable(fmt_sel) && ph == '0 && slot == SL_PAD) |-> $rose(fsync_out));
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx #(
   parameter int SAMPLE_W    = 16,
   parameter int SLOTS       = 32,
   parameter int DIV         = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SAMPLE_W-1:0] smp_data,
   input  logic                smp_valid,
   input  logic                fsync_in,
   input  logic                fmt_sel,
   input  logic                slot_sel,
   input  logic                oe_in,
   output logic                bclk_out,
   output logic                fsync_out,
   output logic                sdata_out,
   output logic                sdata_drive
);
   localparam int PH_W = $clog2(DIV);
   localparam int SL_W = $clog2(SLOTS);

   logic            restart;
   logic [PH_W-1:0] ph;
   logic [SL_W-1:0] slot;
   logic            slot_end;
   logic            frame_start;
   logic            msb;

   sft_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (fsync_in),
      .rise (restart)
   );

   sft_timebase #(.DIV(DIV), .SLOTS(SLOTS)) u_time (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (restart),
      .ph         (ph),
      .slot       (slot),
      .slot_end   (slot_end),
      .frame_start(frame_start)
   );

   sft_payload #(.SAMPLE_W(SAMPLE_W), .SLOTS(SLOTS)) u_pay (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp_data (smp_data),
      .smp_valid(smp_valid),
      .load     (frame_start),
      .shift    (slot_end),
      .slot     (slot),
      .msb      (msb)
   );

   sft_linectl #(.DIV(DIV), .SLOTS(SLOTS), .SAMPLE_W(SAMPLE_W)) u_line (
      .clk        (clk),
      .rst_n      (rst_n),
      .ph         (ph),
      .slot       (slot),
      .msb        (msb),
      .fmt_sel    (fmt_sel),
      .slot_sel   (slot_sel),
      .oe_in      (oe_in),
      .bclk_out   (bclk_out),
      .fsync_out  (fsync_out),
      .sdata_out  (sdata_out),
      .sdata_drive(sdata_drive)
   );
endmodule

// File: tb/serial_frame_tx_tb.sv
module serial_frame_tx_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] smp_data = '0;
   logic        smp_valid = 1'b0;
   logic        fsync_in = 1'b0;
   logic        fmt_sel = 1'b1;
   logic        slot_sel = 1'b0;
   logic        oe_in = 1'b0;
   logic        bclk_out, fsync_out, sdata_out, sdata_drive;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   serial_frame_tx dut_i (
      .clk(clk), .rst_n(rst_n), .smp_data(smp_data), .smp_valid(smp_valid),
      .fsync_in(fsync_in), .fmt_sel(fmt_sel), .slot_sel(slot_sel), .oe_in(oe_in),
      .bclk_out(bclk_out), .fsync_out(fsync_out), .sdata_out(sdata_out),
      .sdata_drive(sdata_drive)
   );

   // Frame model written from the requirements.
   logic [1:0]  m_ph;
   logic [4:0]  m_slot;
   logic [15:0] m_word, m_pend;
   logic        m_s0, m_s1;
   logic        m_start;
   assign m_start = (m_s0 & ~m_s1) | (m_ph == 2'd3 && m_slot == 5'd31);

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph <= '0; m_slot <= '0; m_word <= '0; m_pend <= '0;
         m_s0 <= 1'b1; m_s1 <= 1'b1;
      end else begin
         if (m_start) begin
            m_ph <= '0; m_slot <= '0; m_word <= m_pend;
         end else begin
            m_ph <= m_ph + 2'd1;
            if (m_ph == 2'd3) begin
               m_slot <= m_slot + 5'd1;
               m_word <= {m_word[14:0], 1'b0};
            end
         end
         if (smp_valid) m_pend <= smp_data;
         m_s0 <= fsync_in;
         m_s1 <= m_s0;
      end
   end

   function automatic logic exp_bclk(logic [1:0] p, logic f);
      return f ? (p >= 2'd2) : (p < 2'd2);
   endfunction
   function automatic logic exp_fso(logic [4:0] s, logic f);
      return f ? (s >= 5'd16) : (s == 5'd31);
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R1 bit clock", bclk_out, exp_bclk(m_ph, fmt_sel));
         chk(fmt_sel ? "R6 square marker" : "R5 pulse marker", fsync_out, exp_fso(m_slot, fmt_sel));
         chk(m_slot >= 5'd16 ? "R4 padding" : "R3 data bit", sdata_out, m_word[15]);
         chk("R9 drive", sdata_drive, oe_in == slot_sel);
      end
   end

   task automatic step();
      @(posedge clk); #1;
   endtask
   task automatic wait_at(int s, int p);
      do step(); while (!(m_slot == s[4:0] && m_ph == p[1:0]));
   endtask
   task automatic push(logic [15:0] v);
      smp_data = v; smp_valid = 1'b1;
      step();
      smp_valid = 1'b0;
   endtask
   task automatic capture(output logic [15:0] val, output bit pad_ok);
      val = '0; pad_ok = 1'b1;
      wait_at(0, 0);
      #1;
      for (int i = 0; i < 128; i++) begin
         if (m_ph == 2'd2) begin
            if (m_slot < 5'd16) val = {val[14:0], sdata_out};
            else if (sdata_out) pad_ok = 1'b0;
         end
         step(); #1;
      end
   endtask
   task automatic marker_period(output int n);
      logic prev;
      prev = fsync_out;
      do begin prev = fsync_out; step(); #1; end while (!(fsync_out && !prev));
      n = 0;
      do begin prev = fsync_out; step(); #1; n++; end while (!(fsync_out && !prev));
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] got;
      bit          pad;
      int          n;
      void'($urandom(32'd4711));
      repeat (3) @(posedge clk);
      #2;
      chk("R11 reset marker", fsync_out, 1'b0);
      chk("R11 reset data", sdata_out, 1'b0);
      chk("R11 reset bit clock", bclk_out, 1'b0);
      @(posedge clk); #1 rst_n = 1'b1;

      // R11: first frame after reset sends zeros
      capture(got, pad);
      chk("R11 zeros after reset", got, 16'h0000);

      // R3/R4/R10: known sample, then repeat
      wait_at(5, 0); push(16'hA5C3);
      capture(got, pad);
      chk("R3 msb-first word", got, 16'hA5C3);
      chk("R4 padding zeros", pad, 1'b1);
      capture(got, pad);
      chk("R10 repeat held sample", got, 16'hA5C3);
      wait_at(3, 0); push(16'h1234);
      wait_at(9, 1); push(16'h8001);
      capture(got, pad);
      chk("R10 newest sample wins", got, 16'h8001);

      // R2: free-running period
      marker_period(n);
      chk("R2 frame length", n, 128);

      // R5: pulse marker around frame boundary
      fmt_sel = 1'b0;
      wait_at(31, 1); #1;
      chk("R5 pulse high in last slot", fsync_out, 1'b1);
      wait_at(0, 0); #1;
      chk("R5 pulse low in slot 0", fsync_out, 1'b0);
      fmt_sel = 1'b1;

      // R7: restart latency from a high square marker
      wait_at(20, 1);
      fsync_in = 1'b1;
      n = 0;
      do begin step(); #1; n++; end while (fsync_out && n < 12);
      chk("R7 restart latency", n, 2);
      chk("R7 within eight cycles", n <= 8, 1'b1);
      chk("R7 slot 0 after restart", {m_slot, m_ph}, 7'd0);

      // R8: steady high does not restart
      marker_period(n);
      chk("R8 period with input held high", n, 128);
      fsync_in = 1'b0;
      marker_period(n);
      chk("R8 period with input held low", n, 128);

      // R9: all enable combinations
      for (int k = 0; k < 4; k++) begin
         step();
         oe_in = k[0]; slot_sel = k[1];
         #1;
         chk("R9 enable polarity", sdata_drive, k[0] == k[1]);
      end

      // Random mix, checked each cycle against the model
      begin
         int low_run;
         low_run = 10;
         for (int i = 0; i < 6000; i++) begin
            int unsigned r;
            r = $urandom;
            step();
            if (r % 97 == 0) fmt_sel = ~fmt_sel;
            if (fsync_in) begin
               if (r % 5 == 0) begin fsync_in = 1'b0; low_run = 0; end
            end else begin
               low_run++;
               if (low_run >= 3 && (r % 151 == 0)) fsync_in = 1'b1;
            end
            smp_valid = (r % 13 == 0);
            smp_data  = 16'($urandom);
            if (r % 7 == 0) oe_in = r[20];
            if (r % 211 == 0) slot_sel = r[21];
         end
         smp_valid = 1'b0;
      end

      step();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule